// File: doc/BRIEF.md
# Edge-Configurable Serial Character Receiver

This block receives characters from a single serial data line and delivers each one as a data word on an output stream. Bit timing comes from one of two sources. The first is an internal bit timer whose period is the programmed divisor plus one clock cycles. In that mode a falling edge on the idle data line begins a character, and every bit is sampled near the centre of its period. The second is an external bit clock: each active edge of that clock samples one bit, and the polarity input chooses whether rising or falling edges are active.

A configuration field sets the total character length in bits. That count includes the start bit and any parity and stop bits. When the resynchronisation option is on and the internal timer is in use, every transition on the data line re-centres the timer, so a sender whose rate drifts from the programmed one can still be followed. Both serial inputs pass through two-flop synchronisers before any edge is detected.

A finished character is offered on a valid/ready stream from a single output register. A word that has not yet been accepted stays stable and is never overwritten. A character that completes while the register is still occupied is discarded. The configuration inputs are expected to stay steady while a character is in progress.

Top module: `edge_serial_rx`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, `out_valid` is 0.
- R2: A character of N bits, with N taken from `cfg_frame_len`, is delivered as a word that holds the N-1 bits following the start bit. The first of those bits on the wire goes to word bit 0, and every word bit at index N-1 or above is 0.
- R3: A `cfg_frame_len` value of 0 or 1 is treated as 2, so the character is a start bit followed by one bit.
- R4: With `cfg_use_clk_edge` = 0, a falling edge on the idle data line starts a character. The timer then samples bits every `cfg_divisor`+1 cycles, and the first sample falls near the middle of the start bit.
- R5: In internal timing, if the start bit is sampled high at its midpoint, the character is abandoned, no word is produced, and the receiver waits for the next falling edge.
- R6: With `cfg_use_clk_edge` = 1 and `cfg_clk_falling` = 0, each rising edge of `rx_clk_in` samples one bit. While idle, an active edge that sees the data line low is taken as the start bit.
- R7: With `cfg_use_clk_edge` = 1 and `cfg_clk_falling` = 1, falling edges of `rx_clk_in` sample the bits, and rising edges have no effect.
- R8: With `cfg_resync_on_data` = 1 in internal timing, every data transition during a character reloads the timer to half a bit period. A sender whose bit period is 30% longer than the programmed one is then decoded correctly, provided its data changes on every bit.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_data` stays unchanged. A character that completes during this time is discarded.
- R10: When `out_valid` and `out_ready` are both 1 and no new character completes, `out_valid` is 0 on the next cycle. A character that completes in the same cycle as a handshake is loaded into the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_frame_len | input | LEN_W | Total character length in bits, including the start bit |
| cfg_use_clk_edge | input | 1 | 1: sample on `rx_clk_in` edges; 0: use the internal timer |
| cfg_resync_on_data | input | 1 | Data transitions re-centre the internal timer |
| cfg_clk_falling | input | 1 | 0: rising edges of `rx_clk_in` are active; 1: falling edges are active |
| cfg_divisor | input | DIV_W | Internal bit period minus one, in clock cycles |
| rx_clk_in | input | 1 | External bit clock (asynchronous) |
| rx_data_in | input | 1 | Serial data line, idles high (asynchronous) |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 2**LEN_W | Received character, right-aligned |

## Verification
The bench sends a character with a pulse too short to be a start bit, then a valid character. A receiver that failed to re-check the start bit at its midpoint would turn the glitch into a spurious word. A resynchronisation test sends alternating data 30% slower than the programmed rate. Without re-centring, the sampling point drifts into the neighbouring bit and the decoded word comes out wrong. Frame lengths 0, 1 and 31 and both external clock polarities are exercised, which exposes any off-by-one in the bit count and any edge selection that is inverted. A back-pressure test holds `out_ready` low while a second character arrives. A design that overwrote its output register would present the later word, or would drop the earlier one.

// File: rtl/edge_rx_pkg.sv
package edge_rx_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RECV = 1'b1
  } rx_state_t;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  import edge_rx_pkg::*;

  logic [W-1:0] stage [SYNC_STAGES];
  logic [W-1:0] prev;

  // During reset the chain tracks the inputs, so idle lines show no edge on release
  always_ff @(posedge clk) begin
    stage[0] <= async_in;
    for (int s = 1; s < SYNC_STAGES; s++) begin
      stage[s] <= rst_n ? stage[s-1] : async_in;
    end
    prev <= rst_n ? stage[SYNC_STAGES-1] : async_in;
  end

  assign lvl  = stage[SYNC_STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_ext,
  input  logic             ext_edge,
  input  logic             arm,
  input  logic             resync,
  input  logic             busy,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (arm || resync) begin
      cnt <= divisor >> 1;
    end else if (busy) begin
      cnt <= (cnt == '0) ? divisor : cnt - 1'b1;
    end
  end

  assign tick = use_ext ? ext_edge : (busy && (cnt == '0));
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
  parameter int LEN_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_ext,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              data_lvl,
  input  logic              data_fall,
  input  logic              tick,
  output logic              busy,
  output logic              arm,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  import edge_rx_pkg::*;

  rx_state_t         state;
  logic [LEN_W-1:0]  idx;
  logic [LEN_W-1:0]  last_idx;
  logic [WORD_W-1:0] next_word;

  assign last_idx  = (frame_len < LEN_W'(2)) ? LEN_W'(1) : frame_len - 1'b1;
  assign next_word = word | (WORD_W'(data_lvl) << (idx - 1'b1));
  assign busy      = (state == RX_RECV);
  assign arm       = (state == RX_IDLE) && !use_ext && data_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      idx   <= '0;
      word  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (arm) begin
            state <= RX_RECV;
            idx   <= '0;
            word  <= '0;
          end else if (use_ext && tick && !data_lvl) begin
            state <= RX_RECV;
            idx   <= LEN_W'(1);
            word  <= '0;
          end
        end
        RX_RECV: begin
          if (tick) begin
            if (idx == '0) begin
              if (data_lvl) state <= RX_IDLE;
              else          idx   <= LEN_W'(1);
            end else begin
              word <= next_word;
              if (idx == last_idx) begin
                done  <= 1'b1;
                state <= RX_IDLE;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [WORD_W-1:0] load_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load_req && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_data  <= load_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_serial_rx.sv
module edge_serial_rx #(
  parameter  int LEN_W  = 5,
  parameter  int DIV_W  = 20,
  localparam int WORD_W = 1 << LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_frame_len,
  input  logic              cfg_use_clk_edge,
  input  logic              cfg_resync_on_data,
  input  logic              cfg_clk_falling,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic              rx_clk_in,
  input  logic              rx_data_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int CLK_BIT  = 1;
  localparam int DATA_BIT = 0;

  logic [1:0]        s_lvl, s_rise, s_fall;
  logic              ext_edge, data_edge, resync;
  logic              tick, fr_busy, fr_arm, fr_done;
  logic [WORD_W-1:0] fr_word;

  rx_sync_edge #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({rx_clk_in, rx_data_in}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign ext_edge  = cfg_clk_falling ? s_fall[CLK_BIT] : s_rise[CLK_BIT];
  assign data_edge = s_rise[DATA_BIT] | s_fall[DATA_BIT];
  assign resync    = cfg_resync_on_data && !cfg_use_clk_edge && fr_busy && data_edge;

  rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .use_ext(cfg_use_clk_edge), .ext_edge(ext_edge),
    .arm(fr_arm), .resync(resync), .busy(fr_busy),
    .divisor(cfg_divisor), .tick(tick)
  );

  rx_frame_fsm #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .use_ext(cfg_use_clk_edge), .frame_len(cfg_frame_len),
    .data_lvl(s_lvl[DATA_BIT]), .data_fall(s_fall[DATA_BIT]),
    .tick(tick), .busy(fr_busy), .arm(fr_arm),
    .done(fr_done), .word(fr_word)
  );

  rx_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load_req(fr_done), .load_word(fr_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/edge_serial_rx_chk.sv
module edge_serial_rx_chk #(
  parameter int DIV_W  = 20,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_use_clk_edge,
  input logic [DIV_W-1:0]  cfg_divisor,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              tick,
  input logic              fr_done
);
  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R9
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  p_accept_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !fr_done |=> !out_valid);

  // R2: a completed character reaches the stream when the register is free
  p_push_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && (!out_valid || out_ready) |=> out_valid);

  // R4: internal timer never samples on back-to-back cycles for periods of 3 or more
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_use_clk_edge && tick && (cfg_divisor >= DIV_W'(2)) && $stable(cfg_divisor)
      |=> (!tick || cfg_use_clk_edge));
endmodule

bind edge_serial_rx edge_serial_rx_chk #(.DIV_W(DIV_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cfg_use_clk_edge(cfg_use_clk_edge), .cfg_divisor(cfg_divisor),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .tick(tick), .fr_done(fr_done)
);

// File: tb/edge_serial_rx_tb_top.sv
module edge_serial_rx_tb_top;
  localparam int LEN_W  = 5;
  localparam int DIV_W  = 20;
  localparam int WORD_W = 1 << LEN_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LEN_W-1:0]  cfg_frame_len = LEN_W'(8);
  logic              cfg_use_clk_edge = 1'b0;
  logic              cfg_resync_on_data = 1'b0;
  logic              cfg_clk_falling = 1'b0;
  logic [DIV_W-1:0]  cfg_divisor = DIV_W'(9);
  logic              rx_clk_in = 1'b0;
  logic              rx_data_in = 1'b1;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [WORD_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string cur_req = "R2";
  logic [WORD_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  edge_serial_rx #(.LEN_W(LEN_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_frame_len(cfg_frame_len), .cfg_use_clk_edge(cfg_use_clk_edge),
    .cfg_resync_on_data(cfg_resync_on_data), .cfg_clk_falling(cfg_clk_falling),
    .cfg_divisor(cfg_divisor), .rx_clk_in(rx_clk_in), .rx_data_in(rx_data_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [WORD_W-1:0] got,
                       input logic [WORD_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] expect_word(input logic [WORD_W-1:0] w, input int n);
    int eff = (n < 2) ? 2 : n;
    return w & ((WORD_W'(1) << (eff - 1)) - 1'b1);
  endfunction

  // Internal-timing sender: start bit then the bits of w, LSB first, per cycles each
  task automatic send_int(input logic [WORD_W-1:0] w, input int n, input int per, input bit push);
    int eff = (n < 2) ? 2 : n;
    if (push) exp_q.push_back(expect_word(w, n));
    rx_data_in = 1'b0;
    step(per);
    for (int i = 0; i < eff - 1; i++) begin
      rx_data_in = w[i];
      step(per);
    end
    rx_data_in = 1'b1;
    step(3 * per);
  endtask

  // External-clock sender: data changes in the inactive phase
  task automatic send_ext(input logic [WORD_W-1:0] w, input int n, input bit falling);
    exp_q.push_back(expect_word(w, n));
    for (int i = 0; i < n; i++) begin
      rx_data_in = (i == 0) ? 1'b0 : w[i-1];
      rx_clk_in = falling;
      step(4);
      rx_clk_in = ~falling;
      step(4);
    end
    rx_clk_in = falling;
    rx_data_in = 1'b1;
    step(12);
  endtask

  // Monitor: pops and compares each accepted word
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL %s unexpected word got %h expected none", cur_req, out_data);
      end else begin
        check(cur_req, out_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(4);
    @(negedge clk);
    check("R1", WORD_W'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", WORD_W'(out_valid), '0);
    step(4);

    // R2 R4: internal timing, 10-bit and 31-bit frames
    cur_req = "R2_R4";
    cfg_frame_len = LEN_W'(10);
    send_int(32'h0000_01A5, 10, 10, 1'b1);
    cfg_frame_len = LEN_W'(31);
    send_int(32'h6ABC_DE57, 31, 10, 1'b1);
    cfg_frame_len = LEN_W'(8);
    send_int(32'h0000_0032, 8, 10, 1'b1);

    // R3: short lengths behave as two bits
    cur_req = "R3";
    cfg_frame_len = LEN_W'(1);
    send_int(32'h0000_0001, 1, 10, 1'b1);
    cfg_frame_len = LEN_W'(0);
    send_int(32'h0000_0001, 0, 10, 1'b1);

    // R5: glitch shorter than half a bit is not a start bit
    cur_req = "R5";
    cfg_frame_len = LEN_W'(8);
    rx_data_in = 1'b0;
    step(2);
    rx_data_in = 1'b1;
    step(40);
    @(negedge clk);
    check("R5", WORD_W'(out_valid), '0);
    send_int(32'h0000_0073, 8, 10, 1'b1);

    // R8: sender 30% slow, alternating data, re-centring on
    cur_req = "R8";
    cfg_resync_on_data = 1'b1;
    cfg_frame_len = LEN_W'(9);
    send_int(32'h0000_00D5, 9, 13, 1'b1);
    cfg_resync_on_data = 1'b0;

    // R6: rising-edge external clock
    cur_req = "R6";
    cfg_use_clk_edge = 1'b1;
    cfg_clk_falling = 1'b0;
    rx_clk_in = 1'b0;
    step(6);
    cfg_frame_len = LEN_W'(12);
    send_ext(32'h0000_05A3, 12, 1'b0);

    // R7: falling-edge external clock
    cur_req = "R7";
    cfg_clk_falling = 1'b1;
    step(1);
    rx_clk_in = 1'b1;
    step(6);
    cfg_frame_len = LEN_W'(7);
    send_ext(32'h0000_002D, 7, 1'b1);
    send_ext(32'h0000_0012, 7, 1'b1);

    // R9 R10: back-pressure and drop
    cur_req = "R9";
    cfg_use_clk_edge = 1'b0;
    cfg_clk_falling = 1'b0;
    step(1);
    rx_clk_in = 1'b0;
    step(6);
    cfg_frame_len = LEN_W'(8);
    out_ready = 1'b0;
    send_int(32'h0000_004C, 8, 10, 1'b1);
    @(negedge clk);
    check("R9", WORD_W'(out_valid), WORD_W'(1));
    check("R9", out_data, 32'h0000_004C);
    send_int(32'h0000_0011, 8, 10, 1'b0);
    @(negedge clk);
    check("R9", WORD_W'(out_valid), WORD_W'(1));
    check("R9", out_data, 32'h0000_004C);
    cur_req = "R10";
    step(1);
    out_ready = 1'b1;
    step(3);
    @(negedge clk);
    check("R10", WORD_W'(out_valid), '0);
    check("R9", WORD_W'(exp_q.size()), '0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule